// File: doc/BRIEF.md
# Dual-Bank RAM Pointer Address Generator

This block computes data-RAM addresses for a small DSP core whose internal data memory is split into two banks. Each bank has four 8-bit pointer registers. On an access request the caller supplies a 3-bit pointer index and a 2-bit modifier code. The most significant index bit selects the bank and the two low bits select the pointer inside that bank. The block returns the bank select and the word address one clock later. At the same edge it applies the modifier to the pointer that was used.

The last pointer in each bank is not a storage element. It always reads as zero and ignores loads. When an access uses it, the modifier code is itself the absolute word address (0, 1, 2 or 3) in that bank. This gives four fixed short-form direct addresses per bank.

A separate load port writes a pointer value. A read port returns any pointer value combinationally. Each bank holds 256 words of 16 bits, so an 8-bit pointer covers a whole bank.

Top module: `ptr_agen`

## Requirements
- R1: Index bit 2 selects the bank (0 gives bank 0, 1 gives bank 1) and is returned on `acc_bank`. The read/write flag is forwarded unchanged on `acc_wr`.
- R2: Pointers 3 and 7 always read as 0 on the read port. Loads addressed to them have no effect.
- R3: Modifier 2'b01 on a pointer other than 3/7 accesses the address held in the pointer and then adds one to the pointer.
- R4: Modifier 2'b10 on a pointer other than 3/7 accesses the address held in the pointer and then subtracts one from the pointer.
- R5: Modifier 2'b11 on a pointer other than 3/7 behaves like 2'b01: it accesses at the pointer and then adds one.
- R6: An access through pointer 3 or 7 goes to absolute address 0, 1, 2 or 3 of its bank for modifier 2'b00, 2'b01, 2'b10 or 2'b11 respectively.
- R7: Modifier 2'b00 on a pointer other than 3/7 accesses at the pointer and leaves the pointer unchanged.
- R8: Pointer arithmetic wraps modulo 256: 8'hFF plus one gives 8'h00, and 8'h00 minus one gives 8'hFF.
- R9: `acc_valid`, `acc_bank`, `acc_addr` and `acc_wr` are registered and appear in the cycle after the request. In the request cycle the read port still shows the value the pointer had before the update.
- R10: After synchronous reset all pointers read 0 and `acc_valid` is 0.
- R11: If a load and a post-modify target the same pointer in the same cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_idx | input | 3 | Pointer index; bit 2 is the bank |
| req_mod | input | 2 | Modifier code |
| req_wr | input | 1 | Access is a write |
| ld_en | input | 1 | Load a pointer |
| ld_idx | input | 3 | Pointer to load |
| ld_val | input | 8 | Value to load |
| rd_idx | input | 3 | Pointer to read |
| rd_ptr | output | 8 | Current value of pointer `rd_idx` |
| acc_valid | output | 1 | Registered access strobe |
| acc_bank | output | 1 | Bank of the access |
| acc_addr | output | 8 | Word address inside the bank |
| acc_wr | output | 1 | Registered write flag |

## Verification
The bench drives the fixed pointers with every modifier in both banks. A design that post-modified them, or used their zero value as the address, would return address 0 where 1 to 3 is expected. It steps a pointer across 8'hFF and 8'h00 in both directions, which exposes a carry into a wider register or a saturating update. It also issues a load and a post-modify to the same pointer in one cycle to pin the priority, and it reads the pointer during the request cycle. A design that forwarded the updated value to the read port, or that output the post-modified address instead of the pre-modified one, fails these checks.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;
  typedef enum logic [1:0] {
    MOD_HOLD = 2'b00,
    MOD_INC  = 2'b01,
    MOD_DEC  = 2'b10,
    MOD_INC2 = 2'b11
  } mod_e;
endpackage

// File: rtl/ptr_agen_step.sv
module ptr_agen_step
  import ptr_agen_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic [PTR_W-1:0] cur,
  input  logic             fixed,
  input  mod_e             mode,
  output logic [PTR_W-1:0] addr,
  output logic [PTR_W-1:0] nxt
);
  always_comb begin
    addr = cur;
    nxt  = cur;
    if (fixed) begin
      addr = {{(PTR_W-2){1'b0}}, mode};
    end else begin
      unique case (mode)
        MOD_INC, MOD_INC2: nxt = cur + 1'b1;
        MOD_DEC:           nxt = cur - 1'b1;
        default:           nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int PTR_W  = 8,
  parameter int NPTR_B = 4,
  parameter int SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          upd_en,
  input  logic [SEL_W-1:0]              upd_sel,
  input  logic [PTR_W-1:0]              upd_val,
  input  logic                          ld_en,
  input  logic [SEL_W-1:0]              ld_sel,
  input  logic [PTR_W-1:0]              ld_val,
  output logic [NPTR_B-1:0][PTR_W-1:0]  ptrs
);
  for (genvar g = 0; g < NPTR_B; g++) begin : g_ptr
    if (g == NPTR_B - 1) begin : g_fixed
      // last pointer of a bank is a constant base, never stored
      assign ptrs[g] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          ptrs[g] <= '0;
        else if (ld_en && ld_sel == SEL_W'(g))
          ptrs[g] <= ld_val;
        else if (upd_en && upd_sel == SEL_W'(g))
          ptrs[g] <= upd_val;
      end
    end
  end
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
  import ptr_agen_pkg::*;
#(
  parameter int PTR_W         = 8,
  parameter int PTRS_PER_BANK = 4,
  parameter int NBANKS        = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_idx,
  input  logic [1:0] req_mod,
  input  logic       req_wr,
  input  logic       ld_en,
  input  logic [2:0] ld_idx,
  input  logic [7:0] ld_val,
  input  logic [2:0] rd_idx,
  output logic [7:0] rd_ptr,
  output logic       acc_valid,
  output logic       acc_bank,
  output logic [7:0] acc_addr,
  output logic       acc_wr
);
  localparam int SEL_W  = $clog2(PTRS_PER_BANK);
  localparam int BANK_W = $clog2(NBANKS);
  localparam int IDX_W  = SEL_W + BANK_W;
  localparam int NPTR   = NBANKS * PTRS_PER_BANK;
  localparam logic [SEL_W-1:0] FIX_SEL = SEL_W'(PTRS_PER_BANK - 1);

  logic [NPTR-1:0][PTR_W-1:0] ptr_q;
  logic [BANK_W-1:0] req_bank, ld_bank;
  logic [SEL_W-1:0]  req_sel, ld_sel;
  logic [PTR_W-1:0]  cur_ptr, step_addr, step_nxt;
  logic              req_fixed;
  mod_e              req_mode;

  assign req_bank  = req_idx[IDX_W-1 -: BANK_W];
  assign req_sel   = req_idx[SEL_W-1:0];
  assign ld_bank   = ld_idx[IDX_W-1 -: BANK_W];
  assign ld_sel    = ld_idx[SEL_W-1:0];
  assign req_fixed = (req_sel == FIX_SEL);
  assign req_mode  = mod_e'(req_mod);
  assign cur_ptr   = ptr_q[req_idx];

  ptr_agen_step #(.PTR_W(PTR_W)) u_step (
    .cur   (cur_ptr),
    .fixed (req_fixed),
    .mode  (req_mode),
    .addr  (step_addr),
    .nxt   (step_nxt)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    ptr_bank #(
      .PTR_W  (PTR_W),
      .NPTR_B (PTRS_PER_BANK),
      .SEL_W  (SEL_W)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .upd_en  (req_valid && req_bank == BANK_W'(b)),
      .upd_sel (req_sel),
      .upd_val (step_nxt),
      .ld_en   (ld_en && ld_bank == BANK_W'(b)),
      .ld_sel  (ld_sel),
      .ld_val  (ld_val),
      .ptrs    (ptr_q[b*PTRS_PER_BANK +: PTRS_PER_BANK])
    );
  end

  assign rd_ptr = ptr_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_bank  <= '0;
      acc_addr  <= '0;
      acc_wr    <= 1'b0;
    end else begin
      acc_valid <= req_valid;
      if (req_valid) begin
        acc_bank <= req_bank;
        acc_addr <= step_addr;
        acc_wr   <= req_wr;
      end
    end
  end
endmodule

// File: rtl/ptr_agen_chk.sv
module ptr_agen_chk #(
  parameter int PTR_W         = 8,
  parameter int PTRS_PER_BANK = 4,
  parameter int NBANKS        = 2
) (
  input logic                                      clk,
  input logic                                      rst,
  input logic                                      req_valid,
  input logic [2:0]                                req_idx,
  input logic [1:0]                                req_mod,
  input logic                                      req_wr,
  input logic                                      ld_en,
  input logic [2:0]                                ld_idx,
  input logic [7:0]                                ld_val,
  input logic [2:0]                                rd_idx,
  input logic [7:0]                                rd_ptr,
  input logic                                      acc_valid,
  input logic                                      acc_bank,
  input logic [7:0]                                acc_addr,
  input logic                                      acc_wr,
  input logic [NBANKS*PTRS_PER_BANK-1:0][PTR_W-1:0] ptr_q
);
  logic req_fix, ld_fix, rd_fix, ld_hit;
  assign req_fix = (req_idx[1:0] == 2'b11);
  assign ld_fix  = (ld_idx[1:0] == 2'b11);
  assign rd_fix  = (rd_idx[1:0] == 2'b11);
  assign ld_hit  = ld_en && (ld_idx == req_idx);

  assert_fixed_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_fix |-> rd_ptr == 8'h00);

  assert_bank_wr_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> acc_valid && acc_bank == $past(req_idx[2]) && acc_wr == $past(req_wr));

  assert_addr_pre_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_fix) |=> acc_addr == $past(ptr_q[req_idx]));

  assert_fixed_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_fix) |=> acc_addr == {6'd0, $past(req_mod)});

  assert_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_fix && req_mod[0] && !ld_hit) |=>
      ptr_q[$past(req_idx)] == 8'($past(ptr_q[req_idx]) + 8'd1));

  assert_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_fix && req_mod == 2'b10 && !ld_hit) |=>
      ptr_q[$past(req_idx)] == 8'($past(ptr_q[req_idx]) - 8'd1));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_fix && req_mod == 2'b00 && !ld_hit) |=>
      ptr_q[$past(req_idx)] == $past(ptr_q[req_idx]));

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !ld_fix) |=> ptr_q[$past(ld_idx)] == $past(ld_val));
endmodule

bind ptr_agen ptr_agen_chk #(
  .PTR_W         (PTR_W),
  .PTRS_PER_BANK (PTRS_PER_BANK),
  .NBANKS        (NBANKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_idx   (req_idx),
  .req_mod   (req_mod),
  .req_wr    (req_wr),
  .ld_en     (ld_en),
  .ld_idx    (ld_idx),
  .ld_val    (ld_val),
  .rd_idx    (rd_idx),
  .rd_ptr    (rd_ptr),
  .acc_valid (acc_valid),
  .acc_bank  (acc_bank),
  .acc_addr  (acc_addr),
  .acc_wr    (acc_wr),
  .ptr_q     (ptr_q)
);

// File: tb/sim_ptr_agen.sv
module sim_ptr_agen;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_wr, ld_en;
  logic [2:0] req_idx, ld_idx, rd_idx;
  logic [1:0] req_mod;
  logic [7:0] ld_val, rd_ptr, acc_addr;
  logic       acc_valid, acc_bank, acc_wr;

  always #4 clk = ~clk;

  ptr_agen u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .req_mod(req_mod), .req_wr(req_wr), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_val(ld_val), .rd_idx(rd_idx), .rd_ptr(rd_ptr), .acc_valid(acc_valid),
    .acc_bank(acc_bank), .acc_addr(acc_addr), .acc_wr(acc_wr)
  );

  typedef struct packed { logic bank; logic [7:0] addr; logic wr; } exp_t;
  exp_t       sb[$];
  int         errs = 0;
  int         checks = 0;
  logic [7:0] m [8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected access per strobe
  always @(negedge clk) begin
    if (rst === 1'b0 && acc_valid === 1'b1) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(acc_bank === e.bank && acc_addr === e.addr && acc_wr === e.wr,
              "R1/R3-R8 access", {acc_bank, acc_addr, acc_wr}, {e.bank, e.addr, e.wr});
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    ld_en     = 1'b0;
  endtask

  task automatic access(input int idx, input int md, input bit wr,
                        input bit dold = 1'b0, input logic [7:0] ldv = 8'h00);
    bit   fx;
    exp_t e;
    fx = (idx % 4) == 3;
    @(negedge clk);
    req_valid = 1'b1; req_idx = 3'(idx); req_mod = 2'(md); req_wr = wr;
    rd_idx = 3'(idx); ld_en = dold; ld_idx = 3'(idx); ld_val = ldv;
    e.bank = idx[2];
    e.addr = fx ? 8'(md) : m[idx];
    e.wr   = wr;
    sb.push_back(e);
    #1;
    check(rd_ptr === m[idx], "R9 pre-update read", rd_ptr, m[idx]);
    if (!fx) begin
      if (dold) m[idx] = ldv;
      else if (md == 1 || md == 3) m[idx] = m[idx] + 8'd1;
      else if (md == 2) m[idx] = m[idx] - 8'd1;
    end
  endtask

  task automatic load(input int idx, input logic [7:0] v);
    @(negedge clk);
    req_valid = 1'b0; ld_en = 1'b1; ld_idx = 3'(idx); ld_val = v;
    if ((idx % 4) != 3) m[idx] = v;
  endtask

  task automatic check_ptr(input int idx, input string req);
    @(negedge clk);
    req_valid = 1'b0; ld_en = 1'b0; rd_idx = 3'(idx);
    #1;
    check(rd_ptr === m[idx], req, rd_ptr, m[idx]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    rst = 1'b1; req_valid = 1'b0; req_idx = '0; req_mod = '0; req_wr = 1'b0;
    ld_en = 1'b0; ld_idx = '0; ld_val = '0; rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(acc_valid === 1'b0, "R10 strobe low after reset", acc_valid, 0);
    for (int i = 0; i < 8; i++) check_ptr(i, "R10 pointer zero after reset");

    // loads, including ignored loads to the fixed pointers (R2)
    load(0, 8'h10); load(5, 8'hF0); load(3, 8'h55); load(7, 8'hAA);
    check_ptr(3, "R2 fixed pointer 3 ignores load");
    check_ptr(7, "R2 fixed pointer 7 ignores load");
    check_ptr(0, "R11 load value");

    // R3 / R4 / R5 / R7 on bank 0 pointer 0
    access(0, 1, 1'b0); access(0, 1, 1'b1); access(0, 1, 1'b0);
    access(0, 2, 1'b1);
    access(0, 3, 1'b0); access(0, 3, 1'b0);
    access(0, 0, 1'b1); access(0, 0, 1'b0);
    idle();
    check_ptr(0, "R3/R4/R5/R7 pointer 0 final");

    // R6 fixed short-form addresses in both banks
    for (int md = 0; md < 4; md++) access(3, md, md[0]);
    for (int md = 0; md < 4; md++) access(7, md, !md[0]);
    idle();
    check_ptr(3, "R6 pointer 3 unchanged");
    check_ptr(7, "R6 pointer 7 unchanged");

    // R8 wrap both directions
    load(1, 8'hFF);
    access(1, 1, 1'b0);
    idle();
    check_ptr(1, "R8 wrap up to 00");
    access(1, 2, 1'b1);
    idle();
    check_ptr(1, "R8 wrap down to FF");

    // R1 bank 1 pointers, mixed modifiers back to back
    access(5, 2, 1'b1); access(5, 2, 1'b0); access(6, 1, 1'b1); access(4, 3, 1'b0);
    access(5, 0, 1'b1);
    idle();
    check_ptr(5, "R1/R4 bank 1 pointer 5");
    check_ptr(6, "R1/R3 bank 1 pointer 6");
    check_ptr(4, "R1/R5 bank 1 pointer 4");

    // R11 load and post-modify on same pointer
    access(2, 1, 1'b0, 1'b1, 8'h80);
    idle();
    check_ptr(2, "R11 load wins over post-increment");
    access(6, 2, 1'b1, 1'b1, 8'h33);
    idle();
    check_ptr(6, "R11 load wins over post-decrement");

    repeat (3) idle();
    check(sb.size() == 0, "R9 every request produced a strobe", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule